// File: doc/BRIEF.md
# ADC Result Buffer Address Generator

This block sits between the sequencer of an analog-to-digital converter and a DMA channel. The sequencer reports each finished conversion as a one-cycle event. The event carries the analog input index (0 to 8) and a flag that marks the last result of a sample/conversion sequence. For every accepted result the block produces a buffer write address. It also counts completed sequences and raises a sticky interrupt flag and a one-cycle DMA request at a programmable rate.

Two buffer layouts are offered. In conversion-order layout, results fill consecutive words. The window wraps after the number of results that one interrupt period holds. In scatter/gather layout, every analog input owns a region of `2^bufLog2` words. A slot pointer selects the word inside each region and moves on once per interrupt period. A simple configuration port loads all settings at once. The resolution mode changes only while the block is disabled. High resolution allows one channel per sequence.

Top module: `adc_dma_addr_gen`

## Requirements
- R1: After reset, wrValid, wrAddr, dmaReq, irqFlag and hiResOut are all 0, and the block is disabled.
- R2: With cfgOrderMode=1, each accepted result produces wrValid=1 and wrAddr = cfgBase + orderPtr on the next edge. orderPtr starts at 0 and then increments by one.
- R3: In conversion-order layout, orderPtr returns to 0 when it reaches (cfgSeqPerIrq+1) × channels. Channels is 1 for cfgChans=0, 2 for cfgChans=1, and 4 for cfgChans=2 or 3. It is forced to 1 when high resolution is active.
- R4: With cfgOrderMode=0, the write address is cfgBase + resIndex × 2^cfgBufLog2 + slot, truncated to ADDR_W bits.
- R5: The slot advances by one each time a sequence period completes, and wraps to 0 at 2^cfgBufLog2.
- R6: irqFlag is set on the edge that accepts the last result of sequence number cfgSeqPerIrq+1, and the sequence count then restarts. It stays set until irqClr is high at an edge. A completion in the same cycle as irqClr wins.
- R7: dmaReq is high for exactly the cycle after each completing edge, and is never high while irqFlag is low.
- R8: A configuration write while the block is enabled leaves the resolution mode (hiResOut) unchanged. While disabled, the write loads it.
- R9: While disabled, results are ignored and the sequence count, orderPtr, slot, wrValid, wrAddr and dmaReq are cleared. irqFlag keeps its value.
- R10: A result whose resIndex is above 8 is dropped. It produces no write and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load all cfg* fields |
| cfgEnable | input | 1 | Block enable |
| cfgOrderMode | input | 1 | 1 = conversion order, 0 = scatter/gather |
| cfgHiRes | input | 1 | High-resolution (single channel) mode |
| cfgSeqPerIrq | input | 4 | Sequences per interrupt, minus one |
| cfgChans | input | 2 | Channels per sequence code |
| cfgBufLog2 | input | 3 | Log2 of per-input region words |
| cfgBase | input | ADDR_W | Buffer base address |
| irqClr | input | 1 | Clear the interrupt flag |
| resValid | input | 1 | Conversion result event |
| resIndex | input | 4 | Analog input index of the result |
| resLast | input | 1 | Result ends a sequence |
| wrValid | output | 1 | wrAddr holds a new write address |
| wrAddr | output | ADDR_W | Buffer write address |
| dmaReq | output | 1 | DMA request pulse |
| irqFlag | output | 1 | Sticky interrupt flag |
| hiResOut | output | 1 | Current resolution mode |

## Verification
Every result of the block is registered once. wrValid, wrAddr, dmaReq and irqFlag reflect a result event one rising edge after it is presented. A configuration write is used from the following edge. Disabling clears the state on the second edge after the write that drops the enable. The bench drives inputs at falling edges and advances a behavioural model on each rising edge. It compares every output at the next falling edge, so each comparison sees exactly one edge of latency. Named checks placed right after the stimuli confirm wrap points, the sticky flag, ignored writes and dropped indices.

// File: rtl/adcdma_pkg.sv
package adcdma_pkg;
  localparam int SEQ_W     = 4;
  localparam int LOG2_W    = 3;
  localparam int IDX_W     = 4;
  localparam int CHAN_W    = 2;
  localparam int MAX_INDEX = 8;
  localparam int PTR_W     = SEQ_W + 3;
  localparam int SLOT_W    = (1 << LOG2_W) - 1;

  typedef struct packed {
    logic              enable;
    logic              orderMode;
    logic              hiRes;
    logic [SEQ_W-1:0]  seqSet;
    logic [CHAN_W-1:0] chans;
    logic [LOG2_W-1:0] bufLog2;
  } cfg_t;

  typedef struct packed {
    logic clearAll;
    logic accept;
    logic seqDone;
  } strobe_t;
endpackage

// File: rtl/adcdma_ctrl.sv
module adcdma_ctrl
  import adcdma_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  cfg_t                cfgIn,
  input  logic [ADDR_W-1:0]   cfgBaseIn,
  input  logic                irqClr,
  input  logic                resValid,
  input  logic [IDX_W-1:0]    resIndex,
  input  logic                resLast,
  output cfg_t                cfgQ,
  output logic [ADDR_W-1:0]   baseQ,
  output logic [PTR_W-1:0]    orderLimit,
  output strobe_t             strb,
  output logic                irqFlag,
  output logic                dmaReq
);
  logic [SEQ_W-1:0] seqCnt;
  logic [1:0]       chanShift;
  logic [PTR_W-1:0] setPlus;

  // channel count per sequence as a shift amount
  always_comb begin
    if (cfgQ.hiRes) chanShift = 2'd0;
    else begin
      case (cfgQ.chans)
        2'd0:    chanShift = 2'd0;
        2'd1:    chanShift = 2'd1;
        default: chanShift = 2'd2;
      endcase
    end
    setPlus    = PTR_W'(cfgQ.seqSet) + PTR_W'(1);
    orderLimit = setPlus << chanShift;
  end

  always_comb begin
    strb.clearAll = !cfgQ.enable;
    strb.accept   = cfgQ.enable && resValid && (resIndex <= IDX_W'(MAX_INDEX));
    strb.seqDone  = strb.accept && resLast && (seqCnt >= cfgQ.seqSet);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= '0;
      baseQ <= '0;
    end else if (cfgWe) begin
      cfgQ.enable    <= cfgIn.enable;
      cfgQ.orderMode <= cfgIn.orderMode;
      cfgQ.hiRes     <= cfgQ.enable ? cfgQ.hiRes : cfgIn.hiRes;
      cfgQ.seqSet    <= cfgIn.seqSet;
      cfgQ.chans     <= cfgIn.chans;
      cfgQ.bufLog2   <= cfgIn.bufLog2;
      baseQ          <= cfgBaseIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCnt  <= '0;
      irqFlag <= 1'b0;
      dmaReq  <= 1'b0;
    end else begin
      if (strb.clearAll) begin
        seqCnt <= '0;
        dmaReq <= 1'b0;
      end else begin
        dmaReq <= strb.seqDone;
        if (strb.seqDone)                  seqCnt <= '0;
        else if (strb.accept && resLast)   seqCnt <= seqCnt + SEQ_W'(1);
      end
      if (strb.seqDone)   irqFlag <= 1'b1;
      else if (irqClr)    irqFlag <= 1'b0;
    end
  end

  // R7
  dmareq_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> irqFlag);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

  // R8
  hires_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.enable |=> $stable(cfgQ.hiRes));
endmodule

// File: rtl/adcdma_datapath.sv
module adcdma_datapath
  import adcdma_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  cfg_t               cfgQ,
  input  logic [ADDR_W-1:0]  baseQ,
  input  logic [PTR_W-1:0]   orderLimit,
  input  logic [IDX_W-1:0]   resIndex,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr
);
  localparam int SLOT_CMP_W = SLOT_W + 1;

  logic [PTR_W-1:0]      orderPtr;
  logic [PTR_W-1:0]      orderNext;
  logic [SLOT_W-1:0]     slot;
  logic [SLOT_CMP_W-1:0] slotNext;
  logic [SLOT_CMP_W-1:0] bufWords;
  logic [ADDR_W-1:0]     regionOff;
  logic [ADDR_W-1:0]     scatterAddr;
  logic [ADDR_W-1:0]     orderAddr;

  always_comb begin
    orderNext   = orderPtr + PTR_W'(1);
    slotNext    = SLOT_CMP_W'(slot) + SLOT_CMP_W'(1);
    bufWords    = SLOT_CMP_W'(1) << cfgQ.bufLog2;
    regionOff   = ADDR_W'(resIndex) << cfgQ.bufLog2;
    scatterAddr = baseQ + regionOff + ADDR_W'(slot);
    orderAddr   = baseQ + ADDR_W'(orderPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      orderPtr <= '0;
      slot     <= '0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
    end else begin
      wrValid <= strb.accept;
      if (strb.accept) begin
        if (cfgQ.orderMode) begin
          wrAddr   <= orderAddr;
          orderPtr <= (orderNext >= orderLimit) ? '0 : orderNext;
        end else begin
          wrAddr <= scatterAddr;
        end
      end
      if (strb.seqDone)
        slot <= (slotNext >= bufWords) ? '0 : SLOT_W'(slotNext);
    end
  end

  // R9
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (orderPtr == '0 && slot == '0 && !wrValid));

  // R10
  write_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(strb.accept));
endmodule

// File: rtl/adc_dma_addr_gen.sv
module adc_dma_addr_gen
  import adcdma_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgEnable,
  input  logic              cfgOrderMode,
  input  logic              cfgHiRes,
  input  logic [3:0]        cfgSeqPerIrq,
  input  logic [1:0]        cfgChans,
  input  logic [2:0]        cfgBufLog2,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic              irqClr,
  input  logic              resValid,
  input  logic [3:0]        resIndex,
  input  logic              resLast,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              dmaReq,
  output logic              irqFlag,
  output logic              hiResOut
);
  cfg_t             cfgIn;
  cfg_t             cfgQ;
  strobe_t          strb;
  logic [ADDR_W-1:0] baseQ;
  logic [PTR_W-1:0]  orderLimit;

  always_comb begin
    cfgIn.enable    = cfgEnable;
    cfgIn.orderMode = cfgOrderMode;
    cfgIn.hiRes     = cfgHiRes;
    cfgIn.seqSet    = cfgSeqPerIrq;
    cfgIn.chans     = cfgChans;
    cfgIn.bufLog2   = cfgBufLog2;
  end

  assign hiResOut = cfgQ.hiRes;

  adcdma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn), .cfgBaseIn(cfgBase),
    .irqClr(irqClr), .resValid(resValid), .resIndex(resIndex), .resLast(resLast),
    .cfgQ(cfgQ), .baseQ(baseQ), .orderLimit(orderLimit), .strb(strb),
    .irqFlag(irqFlag), .dmaReq(dmaReq)
  );

  adcdma_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgQ(cfgQ), .baseQ(baseQ),
    .orderLimit(orderLimit), .resIndex(resIndex),
    .wrValid(wrValid), .wrAddr(wrAddr)
  );
endmodule

// File: tb/sim_adc_dma_addr_gen.sv
module sim_adc_dma_addr_gen;
  localparam int AW = 11;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgEnable = 0, cfgOrderMode = 0, cfgHiRes = 0;
  logic [3:0] cfgSeqPerIrq = 0;
  logic [1:0] cfgChans = 0;
  logic [2:0] cfgBufLog2 = 0;
  logic [AW-1:0] cfgBase = 0;
  logic irqClr = 0, resValid = 0, resLast = 0;
  logic [3:0] resIndex = 0;
  logic wrValid, dmaReq, irqFlag, hiResOut;
  logic [AW-1:0] wrAddr;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;

  int mEn, mOrd, mHi, mSet, mCh, mLog, mBase;
  int mSeq, mPtr, mSlot, mIrq, mReq, mVal, mAddr;

  adc_dma_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgOrderMode(cfgOrderMode), .cfgHiRes(cfgHiRes), .cfgSeqPerIrq(cfgSeqPerIrq),
    .cfgChans(cfgChans), .cfgBufLog2(cfgBufLog2), .cfgBase(cfgBase),
    .irqClr(irqClr), .resValid(resValid), .resIndex(resIndex), .resLast(resLast),
    .wrValid(wrValid), .wrAddr(wrAddr), .dmaReq(dmaReq), .irqFlag(irqFlag),
    .hiResOut(hiResOut)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int acc, fin, chn, lim;
    cyc++;
    if (!rstN) begin
      mEn = 0; mOrd = 0; mHi = 0; mSet = 0; mCh = 0; mLog = 0; mBase = 0;
      mSeq = 0; mPtr = 0; mSlot = 0; mIrq = 0; mReq = 0; mVal = 0; mAddr = 0;
    end else begin
      acc = (mEn != 0 && resValid && resIndex <= 8) ? 1 : 0;
      fin = (acc != 0 && resLast && mSeq >= mSet) ? 1 : 0;
      if (mEn == 0) begin
        mSeq = 0; mPtr = 0; mSlot = 0; mVal = 0; mReq = 0; mAddr = 0;
      end else begin
        mVal = acc; mReq = fin;
        if (acc != 0) begin
          if (mOrd != 0) begin
            chn = (mHi != 0 || mCh == 0) ? 1 : (mCh == 1 ? 2 : 4);
            lim = (mSet + 1) * chn;
            mAddr = (mBase + mPtr) & AMASK;
            mPtr = (mPtr + 1 >= lim) ? 0 : mPtr + 1;
          end else begin
            mAddr = (mBase + int'(resIndex) * (1 << mLog) + mSlot) & AMASK;
          end
          if (resLast) mSeq = (fin != 0) ? 0 : mSeq + 1;
        end
        if (fin != 0) mSlot = (mSlot + 1 >= (1 << mLog)) ? 0 : mSlot + 1;
      end
      if (fin != 0) mIrq = 1;
      else if (irqClr) mIrq = 0;
      if (cfgWe) begin
        if (mEn == 0) mHi = cfgHiRes;
        mEn = cfgEnable; mOrd = cfgOrderMode; mSet = cfgSeqPerIrq;
        mCh = cfgChans; mLog = cfgBufLog2; mBase = cfgBase;
      end
    end
  end

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2/R4 wrAddr", wrAddr, mAddr);
      chk("R10 wrValid", wrValid, mVal);
      chk("R7 dmaReq", dmaReq, mReq);
      chk("R6 irqFlag", irqFlag, mIrq);
      chk("R8 hiResOut", hiResOut, mHi);
    end
  end

  task automatic setCfg(int en, int ord, int hi, int sq, int ch, int lg, int base);
    @(negedge clk);
    cfgWe = 1; cfgEnable = en[0]; cfgOrderMode = ord[0]; cfgHiRes = hi[0];
    cfgSeqPerIrq = sq[3:0]; cfgChans = ch[1:0]; cfgBufLog2 = lg[2:0];
    cfgBase = base[AW-1:0];
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic sendRes(int idx, int last);
    @(negedge clk);
    resValid = 1; resIndex = idx[3:0]; resLast = last[0];
    @(negedge clk);
    resValid = 0; resLast = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wrValid", wrValid, 0);
    chk("R1 wrAddr", wrAddr, 0);
    chk("R1 dmaReq", dmaReq, 0);
    chk("R1 irqFlag", irqFlag, 0);
    chk("R1 hiResOut", hiResOut, 0);

    // order layout: 3 sequences of 2 results, base 16
    setCfg(1, 1, 0, 2, 1, 0, 16);
    for (int i = 0; i < 6; i++) begin
      sendRes(i % 9, i % 2);
      chk("R2 order addr", wrAddr, 16 + i);
    end
    chk("R6 irq after 3 sequences", irqFlag, 1);
    sendRes(4, 0);
    chk("R3 order wrap", wrAddr, 16);

    // R8 hi-res write while enabled is ignored
    setCfg(1, 1, 1, 2, 1, 0, 16);
    chk("R8 ignored while enabled", hiResOut, 0);

    // R9 disable clears state, flag stays
    setCfg(0, 1, 1, 2, 1, 0, 16);
    @(negedge clk);
    chk("R9 irq kept", irqFlag, 1);
    chk("R9 addr cleared", wrAddr, 0);
    sendRes(3, 1);
    chk("R9 result ignored", wrValid, 0);
    setCfg(0, 0, 1, 0, 0, 2, 32);
    chk("R8 loaded while disabled", hiResOut, 1);
    @(negedge clk); irqClr = 1; @(negedge clk); irqClr = 0;
    chk("R6 cleared", irqFlag, 0);

    // scatter layout, 4-word regions, one sequence per interrupt
    setCfg(1, 0, 1, 0, 0, 2, 32);
    sendRes(3, 1);
    chk("R4 scatter idx3 slot0", wrAddr, 44);
    chk("R7 request after completion", irqFlag, 1);
    sendRes(8, 1);
    chk("R4 scatter idx8 slot1", wrAddr, 65);
    sendRes(0, 1);
    sendRes(0, 1);
    chk("R5 slot3", wrAddr, 35);
    sendRes(0, 1);
    chk("R5 slot wrap", wrAddr, 32);
    sendRes(9, 1);
    chk("R10 index 9 dropped", wrValid, 0);
    sendRes(0, 1);
    chk("R10 slot not advanced", wrAddr, 33);

    // completion and clear in the same cycle: set wins
    @(negedge clk);
    resValid = 1; resIndex = 2; resLast = 1; irqClr = 1;
    @(negedge clk);
    resValid = 0; resLast = 0; irqClr = 0;
    chk("R6 set beats clear", irqFlag, 1);

    // assorted buffer sizes and rates, model-compared every cycle
    for (int lg = 0; lg < 8; lg += 3) begin
      setCfg(0, 0, 0, 0, 0, lg, 100);
      setCfg(1, 0, 0, 1, 2, lg, 100 + lg);
      for (int k = 0; k < 40; k++) begin
        if (k % 7 == 3) begin @(negedge clk); irqClr = 1; @(negedge clk); irqClr = 0; end
        sendRes((k * 5) % 10, (k % 3 == 2) ? 1 : 0);
      end
    end
    setCfg(1, 1, 0, 3, 3, 0, 2040);
    for (int k = 0; k < 40; k++) sendRes(k % 9, (k % 4 == 3) ? 1 : 0);
    setCfg(0, 1, 1, 3, 3, 0, 2040);
    setCfg(1, 1, 1, 3, 3, 0, 2040);
    for (int k = 0; k < 12; k++) sendRes(1, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule